// File: doc/BRIEF.md
# Watchdog Write-Sequence Exception Monitor

This block sits beside a watchdog's register file and watches every bus write aimed at it. It enforces a two-word unlock handshake, a two-word refresh handshake, a limit on the idle time between the two words of each handshake, a window after reset in which the unlock must complete, and a window after each unlock in which at least one configuration register must be written. Any breach produces a one-cycle exception pulse, registered, together with a 3-bit code naming the cause.

The main counter's expiry arrives as a strobe and is reported through the same output, so the stage that follows needs only one source of exceptions. The window length comes in on a port and is sampled every cycle. Register offsets and sequence words are parameters.

Top module: `wdog_seq_monitor`

## Requirements
- R1: While reset is asserted and in every cycle without an exception, `exc_pulse` is 0 and `exc_cause` is 0. Whenever `exc_pulse` is 1, `exc_cause` is non-zero.
- R2: A cycle with `timeout_in` high gives `exc_pulse` = 1 with cause 1 (time-out) on the next cycle.
- R3: After reset is released, the second unlock word must be accepted at or before the `wct`-th rising edge. If it is not, the pulse appears after exactly `wct` edges with cause 2 (unlock window), and the window then closes.
- R4: The unlock completes when the second word is accepted. A write to any of the four configuration offsets (control 0, time-out value 1, window 2, prescaler 3) must then land within the next `wct` edges. If it does not, the pulse appears `wct` edges after completion with cause 3 (configuration window).
- R5: A write to the unlock offset (5) raises cause 4 (bad unlock word) on the next cycle when its data is not the expected next word. The expected word is 16'hC520 when no sequence is in progress and 16'hD928 after the first word. The sequence then restarts.
- R6: A write to the refresh offset (4) raises cause 5 (bad refresh word) under the same rule. The words are 16'hA602 first and 16'hB480 second.
- R7: The gap is counted in rising edges from the one that takes the first unlock word. A second unlock word arriving with a gap of 20 or less is accepted. If 21 edges pass, the pulse appears after edge 21 with cause 6 (unlock gap), whether or not a write arrives on that edge.
- R8: The same gap rule applies to the refresh sequence, with cause 7 (refresh gap).
- R9: When several causes arise on one edge, the reported code is the one that comes first in this order: 1, 2, 3, 4, 5, 6, 7.
- R10: Configuration writes made while no configuration window is open raise no exception. This covers writes before any unlock and writes after the window was satisfied or expired.
- R11: Writes to offsets other than 4 and 5 neither break nor advance an unlock or refresh sequence in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | AW (4) | Register offset of the write |
| wr_data | input | DW (16) | Write data |
| wct | input | CW (16) | Window length in bus cycles |
| timeout_in | input | 1 | Main counter expiry strobe |
| exc_pulse | output | 1 | Registered exception pulse |
| exc_cause | output | 3 | Cause code, 0 when idle |

## Verification
Refresh handshakes are sent with random gaps from 1 to 24 cycles. These runs separate a correct gap limit from an off-by-one on either side. Random wrong data in the first or second position tells a check that looks only at the first word apart from one that tracks which word is expected next. Directed cases put the closing edge of each window on the edge that accepts or refuses the write, which shows whether the window count includes its last cycle. Coinciding faults are forced onto one edge to expose a wrong priority order. Writes to unrelated offsets in the middle of a handshake show whether the sequence trackers decode addresses.

// File: rtl/wdog_seq_monitor.sv
module wdog_seq_monitor #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int GAP_MAX = 20,
  parameter logic [DW-1:0] UL_W1 = 16'hC520,
  parameter logic [DW-1:0] UL_W2 = 16'hD928,
  parameter logic [DW-1:0] RF_W1 = 16'hA602,
  parameter logic [DW-1:0] RF_W2 = 16'hB480,
  parameter int A_CTRL = 0,
  parameter int A_TOVAL = 1,
  parameter int A_WIN = 2,
  parameter int A_PRESC = 3,
  parameter int A_REFRESH = 4,
  parameter int A_UNLOCK = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] wct,
  input  logic          timeout_in,
  output logic          exc_pulse,
  output logic [2:0]    exc_cause
);
  localparam int GW = $clog2(GAP_MAX + 1);

  logic          ul_stage, rf_stage;
  logic [GW-1:0] ul_gap, rf_gap;
  logic          uw_open, cw_open;
  logic [CW-1:0] uw_cnt, cw_cnt;

  wire ul_wr  = wr_en && (wr_addr == AW'(A_UNLOCK));
  wire rf_wr  = wr_en && (wr_addr == AW'(A_REFRESH));
  wire cfg_wr = wr_en && (wr_addr == AW'(A_CTRL) || wr_addr == AW'(A_TOVAL) ||
                          wr_addr == AW'(A_WIN)  || wr_addr == AW'(A_PRESC));

  wire ul_gap_f = ul_stage && (ul_gap == GW'(GAP_MAX));
  wire rf_gap_f = rf_stage && (rf_gap == GW'(GAP_MAX));
  wire ul_bad   = ul_wr && (wr_data != (ul_stage ? UL_W2 : UL_W1));
  wire rf_bad   = rf_wr && (wr_data != (rf_stage ? RF_W2 : RF_W1));
  wire ul_done  = ul_wr && ul_stage && !ul_bad && !ul_gap_f;
  wire rf_done  = rf_wr && rf_stage && !rf_bad && !rf_gap_f;

  wire uw_last = ({1'b0, uw_cnt} + 1'b1) >= {1'b0, wct};
  wire cw_last = ({1'b0, cw_cnt} + 1'b1) >= {1'b0, wct};
  wire uw_f = uw_open && !ul_done && uw_last;
  wire cw_f = cw_open && !cfg_wr && cw_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ul_stage <= 1'b0;
      ul_gap   <= '0;
    end else if (ul_gap_f || ul_bad || ul_done) begin
      ul_stage <= 1'b0;
      ul_gap   <= '0;
    end else if (ul_wr) begin
      ul_stage <= 1'b1;
      ul_gap   <= '0;
    end else if (ul_stage) begin
      ul_gap   <= ul_gap + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_stage <= 1'b0;
      rf_gap   <= '0;
    end else if (rf_gap_f || rf_bad || rf_done) begin
      rf_stage <= 1'b0;
      rf_gap   <= '0;
    end else if (rf_wr) begin
      rf_stage <= 1'b1;
      rf_gap   <= '0;
    end else if (rf_stage) begin
      rf_gap   <= rf_gap + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uw_open <= 1'b1;
      uw_cnt  <= '0;
    end else if (ul_done || uw_f) begin
      uw_open <= 1'b0;
    end else if (uw_open) begin
      uw_cnt  <= uw_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_open <= 1'b0;
      cw_cnt  <= '0;
    end else if (ul_done) begin
      cw_open <= 1'b1;
      cw_cnt  <= '0;
    end else if (cfg_wr || cw_f) begin
      cw_open <= 1'b0;
    end else if (cw_open) begin
      cw_cnt  <= cw_cnt + 1'b1;
    end
  end

  logic [2:0] cause_d;
  always_comb begin
    if (timeout_in)    cause_d = 3'd1;
    else if (uw_f)     cause_d = 3'd2;
    else if (cw_f)     cause_d = 3'd3;
    else if (ul_bad)   cause_d = 3'd4;
    else if (rf_bad)   cause_d = 3'd5;
    else if (ul_gap_f) cause_d = 3'd6;
    else if (rf_gap_f) cause_d = 3'd7;
    else               cause_d = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_pulse <= 1'b0;
      exc_cause <= 3'd0;
    end else begin
      exc_pulse <= (cause_d != 3'd0);
      exc_cause <= cause_d;
    end
  end
endmodule

// File: rtl/wdog_seq_monitor_chk.sv
module wdog_seq_monitor_chk #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter logic [DW-1:0] UL_W1 = 16'hC520,
  parameter logic [DW-1:0] UL_W2 = 16'hD928,
  parameter logic [DW-1:0] RF_W1 = 16'hA602,
  parameter logic [DW-1:0] RF_W2 = 16'hB480,
  parameter int A_REFRESH = 4,
  parameter int A_UNLOCK = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          timeout_in,
  input logic          exc_pulse,
  input logic [2:0]    exc_cause
);
  a_r1_quiet_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_pulse |-> exc_cause == 3'd0);

  a_r1_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> exc_cause != 3'd0);

  a_r2_timeout_reported: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_in |=> exc_pulse && exc_cause == 3'd1);

  a_r5_foreign_unlock_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(A_UNLOCK) && wr_data != UL_W1 && wr_data != UL_W2)
      |=> exc_pulse);

  a_r6_foreign_refresh_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(A_REFRESH) && wr_data != RF_W1 && wr_data != RF_W2)
      |=> exc_pulse);

  a_r9_timeout_outranks: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_pulse && exc_cause != 3'd1) |-> !$past(timeout_in));
endmodule

bind wdog_seq_monitor wdog_seq_monitor_chk #(
  .AW(AW), .DW(DW), .UL_W1(UL_W1), .UL_W2(UL_W2), .RF_W1(RF_W1), .RF_W2(RF_W2),
  .A_REFRESH(A_REFRESH), .A_UNLOCK(A_UNLOCK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .timeout_in(timeout_in), .exc_pulse(exc_pulse), .exc_cause(exc_cause)
);

// File: tb/test_wdog_seq_monitor.sv
`timescale 1ns/1ps
module test_wdog_seq_monitor;
  localparam logic [3:0] A_CTRL = 4'd0, A_WIN = 4'd2, A_PRESC = 4'd3, A_RF = 4'd4, A_UL = 4'd5;
  localparam logic [15:0] UL1 = 16'hC520, UL2 = 16'hD928, RF1 = 16'hA602, RF2 = 16'hB480;
  localparam int GAP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] wct = 16'd1000;
  logic timeout_in = 1'b0;
  logic exc_pulse;
  logic [2:0] exc_cause;

  int n_cmp = 0, n_bad = 0, pulses = 0;
  int last_cause = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_seq_monitor i_wdog_seq_monitor (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wct(wct), .timeout_in(timeout_in), .exc_pulse(exc_pulse), .exc_cause(exc_cause)
  );

  function automatic int exp_rf_gap(int g);
    return (g > GAP) ? 7 : 0;
  endfunction

  function automatic int exp_rf_word(bit second, logic [15:0] d);
    return (d != (second ? RF2 : RF1)) ? 5 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (exc_pulse) begin
      pulses++;
      last_cause = int'(exc_cause);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_reset(int w);
    rst_n = 1'b0; wct = 16'(w); wr_en = 1'b0; timeout_in = 1'b0;
    step(); step();
    rst_n = 1'b1;
    pulses = 0; last_cause = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int p0, early;
    void'($urandom(32'd4242));

    // R1: reset state
    rst_n = 1'b0;
    step();
    chk("R1 pulse in reset", int'(exc_pulse), 0);
    chk("R1 cause in reset", int'(exc_cause), 0);

    // R3: unlock window expiry at edge wct
    do_reset(30);
    early = 0;
    for (int i = 1; i <= 30; i++) begin
      step();
      if (i < 30 && exc_pulse) early++;
      if (i == 30) begin
        chk("R3 pulse at edge wct", int'(exc_pulse), 1);
        chk("R3 cause unlock window", int'(exc_cause), 2);
      end
    end
    chk("R3 no early pulse", early, 0);
    step();
    chk("R1 idle cause after pulse", int'(exc_cause), 0);

    // R3: completion on the last edge of the window is accepted
    do_reset(30);
    idle(28);
    wr(A_UL, UL1);
    wr(A_UL, UL2);
    wr(A_CTRL, 16'h0001);
    idle(40);
    chk("R3 R4 completion on last edge", pulses, 0);

    // R4: configuration window expiry
    p0 = pulses; early = 0;
    wr(A_UL, UL1); wr(A_UL, UL2);
    for (int i = 1; i <= 30; i++) begin
      step();
      if (i < 30 && exc_pulse) early++;
      if (i == 30) chk("R4 cause config window", int'(exc_pulse) * int'(exc_cause), 3);
    end
    chk("R4 no early pulse", early, 0);
    // R10: late configuration write ignored
    p0 = pulses;
    wr(A_WIN, 16'h00FF); idle(5);
    chk("R10 late config write", pulses - p0, 0);

    // R4: configuration write on the last edge
    p0 = pulses;
    wr(A_UL, UL1); wr(A_UL, UL2);
    idle(29);
    wr(A_PRESC, 16'h0003);
    idle(40);
    chk("R4 config write on last edge", pulses - p0, 0);
    // R10: extra configuration write after satisfied window
    wr(A_CTRL, 16'h0002); idle(3);
    chk("R10 config write after satisfied", pulses - p0, 0);

    // R10: configuration write before any unlock
    do_reset(1000);
    wr(A_CTRL, 16'h0005); idle(5);
    chk("R10 config write before unlock", pulses, 0);
    wr(A_UL, UL1); wr(A_UL, UL2); wr(A_CTRL, 16'h0);

    // R5: bad unlock words
    wr(A_UL, 16'h1234);
    chk("R5 foreign first word", int'(exc_pulse) * int'(exc_cause), 4);
    wr(A_UL, UL2);
    chk("R5 second word out of order", int'(exc_pulse) * int'(exc_cause), 4);
    wr(A_UL, UL1); wr(A_UL, UL1);
    chk("R5 wrong second word", int'(exc_pulse) * int'(exc_cause), 4);

    // R6: bad refresh words
    wr(A_RF, UL1);
    chk("R6 foreign first word", int'(exc_pulse) * int'(exc_cause), 5);
    wr(A_RF, RF1); wr(A_RF, 16'h0000);
    chk("R6 wrong second word", int'(exc_pulse) * int'(exc_cause), 5);

    // R7: unlock gap 20 accepted, 21 faults
    p0 = pulses;
    wr(A_UL, UL1); idle(GAP - 1); wr(A_UL, UL2); wr(A_CTRL, 16'h0);
    chk("R7 gap of 20 accepted", pulses - p0, 0);
    wr(A_UL, UL1); idle(GAP);
    chk("R7 no pulse before edge 21", pulses - p0, 0);
    step();
    chk("R7 cause unlock gap", int'(exc_pulse) * int'(exc_cause), 6);

    // R8: refresh gap
    p0 = pulses;
    wr(A_RF, RF1); idle(GAP - 1); wr(A_RF, RF2);
    chk("R8 gap of 20 accepted", pulses - p0, 0);
    wr(A_RF, RF1); idle(GAP);
    step();
    chk("R8 cause refresh gap", int'(exc_pulse) * int'(exc_cause), 7);

    // R11: unrelated writes inside a handshake
    p0 = pulses;
    wr(A_RF, RF1); wr(4'hE, 16'hFFFF); wr(A_CTRL, 16'h1); wr(A_RF, RF2);
    wr(A_UL, UL1); wr(4'hF, 16'h0); wr(A_UL, UL2); wr(A_CTRL, 16'h0);
    chk("R11 unrelated writes", pulses - p0, 0);

    // R2: time-out strobe
    timeout_in = 1'b1; step(); timeout_in = 1'b0;
    chk("R2 time-out cause", int'(exc_pulse) * int'(exc_cause), 1);

    // R9: time-out with bad refresh on one edge
    timeout_in = 1'b1; wr(A_RF, 16'h5555); timeout_in = 1'b0;
    chk("R9 time-out over bad refresh", int'(exc_cause), 1);

    // R9: config window expiry with bad unlock on one edge
    do_reset(25);
    wr(A_UL, UL1); wr(A_UL, UL2);
    idle(24);
    p0 = pulses;
    wr(A_UL, 16'h0BAD);
    chk("R9 config window over bad unlock", int'(exc_cause), 3);
    chk("R9 single pulse", pulses - p0, 1);

    // R9: unlock window expiry with bad unlock on one edge
    do_reset(20);
    idle(19);
    wr(A_UL, 16'h7777);
    chk("R9 unlock window over bad unlock", int'(exc_cause), 2);

    // random refresh traffic (R6, R8)
    do_reset(1000);
    wr(A_UL, UL1); wr(A_UL, UL2); wr(A_CTRL, 16'h0);
    for (int it = 0; it < 60; it++) begin
      int kind, g, e;
      logic [15:0] d;
      kind = int'($urandom % 3);
      p0 = pulses; last_cause = 0;
      if (kind == 0) begin
        g = 1 + int'($urandom % 24);
        e = exp_rf_gap(g);
        wr(A_RF, RF1);
        if (g <= GAP) begin
          idle(g - 1); wr(A_RF, RF2);
        end else begin
          idle(GAP + 1);
        end
        chk("R8 random gap cause", last_cause, e);
        chk("R8 random gap count", pulses - p0, (e != 0) ? 1 : 0);
      end else begin
        d = 16'($urandom);
        if (d == RF1 || d == RF2) d = 16'h0;
        if (kind == 2) wr(A_RF, RF1);
        e = exp_rf_word(kind == 2, d);
        wr(A_RF, d);
        chk("R6 random word cause", last_cause, e);
        chk("R6 random word count", pulses - p0, 1);
      end
      idle(1);
    end

    finish_run();
  end
endmodule